// File: doc/BRIEF.md
# Posted Column Command Scheduler

This block sits on the controller side of a DDR2-style SDRAM port that accepts column commands early. Every cycle it takes one command (idle, row open, read or write) with a bank index. It keeps a per-bank count of cycles since the row was opened. A column command may arrive before the row-to-column delay has run out, provided a nonzero additive latency is configured. The block then works out when the command takes effect inside the memory and when its data occupies the shared data bus.

Read data is expected AL + CL clocks after the read command. Write data must be driven one clock earlier than a read would arrive. A burst moves two beats per clock, so BL4 holds the bus for two cycles and BL8 for four. The controller follows three strobes: an internal-issue pulse, a read-data-valid window and a write-data-enable window. A command whose bus window would overlap a window already booked is refused at once. Commands to banks that were never opened, and early commands with no additive latency, are dropped and flagged.

Top module: `pcas_sched`

## Requirements
- R1: Command codes on `cmd_i` are 0 idle, 1 row open, 2 read, 3 write. A read or write to a bank that has had no row open since reset is dropped, and `noact_err_o` is high for one cycle, in the cycle after the edge that samples it.
- R2: A column command sampled d edges after its bank's row open, with d < TRCD and `al_i` = 0, is dropped, and `trcd_err_o` pulses in the cycle after. With d >= TRCD, or with `al_i` nonzero and any d >= 1, it is accepted.
- R3: For an accepted column command sampled at edge e, `iss_o` is high for one cycle, the cycle after edge e + AL.
- R4: For an accepted read sampled at edge e, `rd_valid_o` is high in the cycles after edges e + AL + CL onward, for the burst's cycle count.
- R5: For an accepted write sampled at edge e, `wr_en_o` starts one cycle earlier than a read would, after edge e + AL + CL - 1, and lasts for the burst's cycle count.
- R6: `bl8_i` = 1 selects BL8, a window of 4 cycles. `bl8_i` = 0 selects BL4, a window of 2 cycles. CL must lie in 2 to 2^CL_W - 1.
- R7: A column command that passes R1 and R2 but whose window would share any cycle with a pending read or write window raises `busy_o` combinationally in the cycle it is presented, and is dropped. `rd_valid_o` and `wr_en_o` are never high together.
- R8: Column commands whose windows do not overlap are all delivered, even when several are in flight at once. Two reads two cycles apart with BL4 give one unbroken 4-cycle valid window.
- R9: Synchronous active-high `rst` clears every pending window, every strobe and flag, and every bank's open state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command code (idle, row open, read, write) |
| bank_i | input | BANK_W | Bank index of the command |
| al_i | input | AL_W | Additive latency in clocks |
| cl_i | input | CL_W | CAS latency in clocks |
| bl8_i | input | 1 | 1 selects BL8, 0 selects BL4 |
| rd_valid_o | output | 1 | Read data expected on the bus this cycle |
| wr_en_o | output | 1 | Write data must be driven this cycle |
| iss_o | output | 1 | A column command takes effect internally this cycle |
| busy_o | output | 1 | Presented column command refused for a bus clash |
| noact_err_o | output | 1 | Column command to a bank never opened |
| trcd_err_o | output | 1 | Early column command with zero additive latency |

## Verification
The bound checker watches, on every cycle, that read and write windows never overlap, that a refusal only occurs while a column command is presented, that a delay error only follows a zero additive latency, that the two error flags stay exclusive, and that reset empties the strobes. Whether a window lands on the exact cycle set by AL and CL, and whether it lasts the right length for the burst setting, is shown only by the bench's sweep over AL, CL, burst length and direction. The same holds for the delay boundary at TRCD and for refusals against windows already booked.

// File: rtl/pcas_pkg.sv
`timescale 1ns/1ps
package pcas_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  // bus cycles occupied by one burst (two beats per clock)
  function automatic logic [2:0] burst_cycles(input logic bl8);
    return bl8 ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/pcas_bank_timers.sv
`timescale 1ns/1ps
module pcas_bank_timers #(
  parameter int NBANK  = 4,
  parameter int TRCD   = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              live_o,
  output logic              ripe_o
);

  localparam int CNT_W = $clog2(TRCD + 1);

  logic [NBANK-1:0] live_q;
  logic [CNT_W-1:0] cnt_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        live_q[b] <= 1'b0;
        cnt_q[b]  <= '0;
      end else if (act_i && (bank_i == BANK_W'(b))) begin
        live_q[b] <= 1'b1;
        cnt_q[b]  <= CNT_W'(1);
      end else if (cnt_q[b] < CNT_W'(TRCD)) begin
        cnt_q[b]  <= cnt_q[b] + 1'b1;
      end
    end
  end

  assign live_o = live_q[bank_i];
  assign ripe_o = cnt_q[bank_i] >= CNT_W'(TRCD);

endmodule

// File: rtl/pcas_slot_pipe.sv
`timescale 1ns/1ps
module pcas_slot_pipe #(
  parameter int DEPTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] ins_i,
  output logic [DEPTH-1:0] pend_o,
  output logic             strobe_o
);

  // bit j of the map is the cycle after j more edges from now
  logic [DEPTH-1:0] map_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q    <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= map_q[0] | ins_i[0];
      map_q    <= (map_q >> 1) | (ins_i >> 1);
    end
  end

  assign pend_o = map_q;

endmodule

// File: rtl/pcas_sched.sv
`timescale 1ns/1ps
module pcas_sched
  import pcas_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int TRCD  = 4,
  parameter int AL_W  = 3,
  parameter int CL_W  = 3,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [AL_W-1:0]   al_i,
  input  logic [CL_W-1:0]   cl_i,
  input  logic              bl8_i,
  output logic              rd_valid_o,
  output logic              wr_en_o,
  output logic              iss_o,
  output logic              busy_o,
  output logic              noact_err_o,
  output logic              trcd_err_o
);

  localparam int AL_MAX = (1 << AL_W) - 1;
  localparam int CL_MAX = (1 << CL_W) - 1;
  localparam int DEPTH  = AL_MAX + CL_MAX + 4;
  localparam int OFF_W  = $clog2(DEPTH + 1);

  cmd_e cmd;
  logic is_col, is_rd, live, ripe, col_ok, clash, accept;
  logic [OFF_W-1:0] off_rd, off;
  logic [2:0]       blen;
  logic [DEPTH-1:0] col_mask, iss_mask, rd_ins, wr_ins, iss_ins;
  logic [DEPTH-1:0] rd_pend, wr_pend, iss_pend_unused;

  assign cmd    = cmd_e'(cmd_i);
  assign is_rd  = (cmd == CMD_RD);
  assign is_col = is_rd || (cmd == CMD_WR);

  pcas_bank_timers #(.NBANK(NBANK), .TRCD(TRCD), .BANK_W(BANK_W)) u_banks (
    .clk    (clk),
    .rst    (rst),
    .act_i  (cmd == CMD_ACT),
    .bank_i (bank_i),
    .live_o (live),
    .ripe_o (ripe)
  );

  // data window offset: read at AL+CL, write one clock earlier
  assign off_rd = OFF_W'(al_i) + OFF_W'(cl_i);
  assign off    = is_rd ? off_rd : off_rd - 1'b1;
  assign blen   = burst_cycles(bl8_i);

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      col_mask[j] = (j >= int'(off)) && (j < int'(off) + int'(blen));
      iss_mask[j] = (j == int'(al_i));
    end
  end

  assign col_ok = is_col && live && !(al_i == '0 && !ripe);
  assign clash  = |(col_mask & (rd_pend | wr_pend));
  assign accept = col_ok && !clash;
  assign busy_o = col_ok && clash;

  assign rd_ins  = (accept && is_rd)  ? col_mask : '0;
  assign wr_ins  = (accept && !is_rd) ? col_mask : '0;
  assign iss_ins = accept ? iss_mask : '0;

  pcas_slot_pipe #(.DEPTH(DEPTH)) u_rd_pipe (
    .clk(clk), .rst(rst), .ins_i(rd_ins), .pend_o(rd_pend), .strobe_o(rd_valid_o)
  );

  pcas_slot_pipe #(.DEPTH(DEPTH)) u_wr_pipe (
    .clk(clk), .rst(rst), .ins_i(wr_ins), .pend_o(wr_pend), .strobe_o(wr_en_o)
  );

  pcas_slot_pipe #(.DEPTH(DEPTH)) u_iss_pipe (
    .clk(clk), .rst(rst), .ins_i(iss_ins), .pend_o(iss_pend_unused), .strobe_o(iss_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      noact_err_o <= 1'b0;
      trcd_err_o  <= 1'b0;
    end else begin
      noact_err_o <= is_col && !live;
      trcd_err_o  <= is_col && live && al_i == '0 && !ripe;
    end
  end

endmodule

// File: rtl/pcas_sched_chk.sv
`timescale 1ns/1ps
module pcas_sched_chk
  import pcas_pkg::*;
#(
  parameter int AL_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      cmd_i,
  input logic [AL_W-1:0] al_i,
  input logic            rd_valid_o,
  input logic            wr_en_o,
  input logic            iss_o,
  input logic            busy_o,
  input logic            noact_err_o,
  input logic            trcd_err_o
);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !rd_valid_o && !wr_en_o && !iss_o && !noact_err_o && !trcd_err_o);

  // R7
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid_o && wr_en_o));

  // R7
  busy_on_col_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cmd_i == CMD_RD || cmd_i == CMD_WR));

  // R2
  trcd_zero_al_chk: assert property (@(posedge clk) disable iff (rst)
    trcd_err_o |-> ($past(al_i) == '0 && ($past(cmd_i) == CMD_RD || $past(cmd_i) == CMD_WR)));

  // R1
  noact_col_chk: assert property (@(posedge clk) disable iff (rst)
    noact_err_o |-> ($past(cmd_i) == CMD_RD || $past(cmd_i) == CMD_WR));

  // R2
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(noact_err_o && trcd_err_o));

endmodule

bind pcas_sched pcas_sched_chk #(.AL_W(AL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_i       (cmd_i),
  .al_i        (al_i),
  .rd_valid_o  (rd_valid_o),
  .wr_en_o     (wr_en_o),
  .iss_o       (iss_o),
  .busy_o      (busy_o),
  .noact_err_o (noact_err_o),
  .trcd_err_o  (trcd_err_o)
);

// File: tb/pcas_sched_bench.sv
`timescale 1ns/1ps
module pcas_sched_bench;
  import pcas_pkg::*;

  localparam int TRCD = 4;
  localparam int W    = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cmd_i = 2'd0;
  logic [1:0] bank_i = 2'd0;
  logic [2:0] al_i = 3'd0;
  logic [2:0] cl_i = 3'd3;
  logic bl8_i = 1'b0;
  logic rd_valid_o, wr_en_o, iss_o, busy_o, noact_err_o, trcd_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcas_sched #(.NBANK(4), .TRCD(TRCD), .AL_W(3), .CL_W(3)) u_pcas_sched (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .al_i(al_i),
    .cl_i(cl_i), .bl8_i(bl8_i), .rd_valid_o(rd_valid_o), .wr_en_o(wr_en_o),
    .iss_o(iss_o), .busy_o(busy_o), .noact_err_o(noact_err_o), .trcd_err_o(trcd_err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] win(input int off, input int len);
    logic [W-1:0] m;
    for (int j = 0; j < W; j++) m[j] = (j >= off) && (j < off + len);
    return m;
  endfunction

  task automatic cfg(input int al, input int cl, input bit bl8);
    al_i = 3'(al); cl_i = 3'(cl); bl8_i = bl8;
  endtask

  // open a row, then return at the negedge where a column command is d edges later
  task automatic open_row(input logic [1:0] bnk, input int d);
    cmd_i = CMD_ACT; bank_i = bnk;
    @(negedge clk);
    cmd_i = CMD_NOP;
    for (int i = 1; i < d; i++) @(negedge clk);
  endtask

  // command a now, optional command b gap edges later; record W cycles of outputs
  task automatic pair(input cmd_e a, input cmd_e b, input int gap,
                      output logic [W-1:0] rv, output logic [W-1:0] wv,
                      output logic [W-1:0] iv, output logic [W-1:0] nv,
                      output logic [W-1:0] tv, output logic bz);
    bz = 1'b0;
    cmd_i = a;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      cmd_i = CMD_NOP;
      if (k + 1 == gap) begin
        cmd_i = b;
        #1 bz = busy_o;
      end
      rv[k] = rd_valid_o; wv[k] = wr_en_o; iv[k] = iss_o;
      nv[k] = noact_err_o; tv[k] = trcd_err_o;
    end
    cmd_i = CMD_NOP;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rv, wv, iv, nv, tv;
    logic bz;
    int rl, cyc;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk({rd_valid_o, wr_en_o, iss_o, busy_o, noact_err_o, trcd_err_o} == 6'd0,
        "R9", "outputs in reset", {26'd0, rd_valid_o, wr_en_o, iss_o, busy_o, noact_err_o, trcd_err_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 column to a bank never opened
    cfg(0, 3, 0);
    bank_i = 2'd2;
    pair(CMD_RD, CMD_NOP, 0, rv, wv, iv, nv, tv, bz);
    chk(nv == win(0, 1), "R1", "noact flag", 32'(nv), 32'(win(0, 1)));
    chk(rv == '0 && iv == '0, "R1", "dropped read strobes", 32'(rv | iv), 0);

    // R3 R4 R5 R6 sweep over direction, AL, CL, burst
    for (int op = 0; op < 2; op++)
      for (int al = 0; al < 4; al++)
        for (int cl = 2; cl < 6; cl++)
          for (int bl = 0; bl < 2; bl++) begin
            cfg(al, cl, bit'(bl));
            open_row(2'd0, TRCD);
            pair(op == 0 ? CMD_RD : CMD_WR, CMD_NOP, 0, rv, wv, iv, nv, tv, bz);
            rl = al + cl;
            cyc = bl ? 4 : 2;
            if (op == 0)
              chk(rv == win(rl, cyc) && wv == '0 && iv == win(al, 1) && (nv | tv) == '0,
                  "R4", "read window / R3 issue / R6 burst", 32'(rv), 32'(win(rl, cyc)));
            else
              chk(wv == win(rl - 1, cyc) && rv == '0 && iv == win(al, 1) && (nv | tv) == '0,
                  "R5", "write window / R3 issue / R6 burst", 32'(wv), 32'(win(rl - 1, cyc)));
          end

    // R2 early column with AL zero, one cycle short of TRCD
    cfg(0, 3, 0);
    open_row(2'd1, TRCD - 1);
    pair(CMD_RD, CMD_NOP, 0, rv, wv, iv, nv, tv, bz);
    chk(tv == win(0, 1), "R2", "delay flag", 32'(tv), 32'(win(0, 1)));
    chk(rv == '0 && iv == '0, "R2", "early read dropped", 32'(rv | iv), 0);

    // R2 exactly at TRCD with AL zero
    open_row(2'd1, TRCD);
    pair(CMD_RD, CMD_NOP, 0, rv, wv, iv, nv, tv, bz);
    chk(rv == win(3, 2) && tv == '0, "R2", "read at delay boundary", 32'(rv), 32'(win(3, 2)));

    // R2 posted read right after row open, AL=2 CL=3
    cfg(2, 3, 0);
    open_row(2'd3, 1);
    pair(CMD_RD, CMD_NOP, 0, rv, wv, iv, nv, tv, bz);
    chk(rv == win(5, 2) && tv == '0 && iv == win(2, 1), "R2", "posted read", 32'(rv), 32'(win(5, 2)));

    // R7 read then write two edges later: windows 5..6 and 6..7 clash
    open_row(2'd3, 1);
    pair(CMD_RD, CMD_WR, 2, rv, wv, iv, nv, tv, bz);
    chk(bz == 1'b1, "R7", "busy on clash", 32'(bz), 1);
    chk(rv == win(5, 2) && wv == '0, "R7", "clashing write dropped", 32'(wv), 0);

    // R7 R5 read then write three edges later: write at 7..8
    open_row(2'd3, 1);
    pair(CMD_RD, CMD_WR, 3, rv, wv, iv, nv, tv, bz);
    chk(bz == 1'b0, "R7", "no busy when disjoint", 32'(bz), 0);
    chk(wv == win(7, 2) && rv == win(5, 2), "R5", "write after read", 32'(wv), 32'(win(7, 2)));
    chk(iv == (win(2, 1) | win(5, 1)), "R3", "two issue pulses", 32'(iv), 32'(win(2, 1) | win(5, 1)));

    // R8 two BL4 reads two edges apart give one 4-cycle window
    cfg(0, 3, 0);
    open_row(2'd0, TRCD);
    pair(CMD_RD, CMD_RD, 2, rv, wv, iv, nv, tv, bz);
    chk(bz == 1'b0 && rv == win(3, 4), "R8", "back-to-back reads", 32'(rv), 32'(win(3, 4)));

    // R7 two BL8 reads two edges apart clash
    cfg(0, 3, 1);
    open_row(2'd0, TRCD);
    pair(CMD_RD, CMD_RD, 2, rv, wv, iv, nv, tv, bz);
    chk(bz == 1'b1 && rv == win(3, 4), "R7", "BL8 read clash", 32'(rv), 32'(win(3, 4)));

    // R7 write then read one edge later with BL8: 2..5 against 4..7
    open_row(2'd0, TRCD);
    pair(CMD_WR, CMD_RD, 1, rv, wv, iv, nv, tv, bz);
    chk(bz == 1'b1 && rv == '0 && wv == win(2, 4), "R7", "read after write clash", 32'(wv), 32'(win(2, 4)));

    // R9 reset while a read is in flight, bank state also cleared
    cfg(3, 5, 1);
    open_row(2'd0, TRCD);
    cmd_i = CMD_RD;
    @(negedge clk);
    cmd_i = CMD_NOP; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cfg(0, 3, 0);
    bank_i = 2'd0;
    pair(CMD_RD, CMD_NOP, 0, rv, wv, iv, nv, tv, bz);
    chk(rv == '0 && iv == '0, "R9", "pending read flushed", 32'(rv | iv), 0);
    chk(nv == win(0, 1), "R9", "bank open state cleared", 32'(nv), 32'(win(0, 1)));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule